// File: doc/BRIEF.md
# RAM-Descriptor Single-Transfer Engine

This block moves one data item per activation without keeping any channel state in its own flip-flops between activations. A requester pulses an activation input together with the byte address of a descriptor held in shared on-chip RAM. The engine then runs a fixed sequence:

- It copies the six descriptor words into working registers.
- It reads one byte or one 16-bit word from the source address.
- It writes that item to the destination address.
- It advances both addresses and the transfer count.
- It writes all six words back to the same RAM location.
- It raises a one-cycle completion pulse.

The host cannot reach the working registers directly. Software keeps one descriptor per channel in RAM and edits it there between activations.

The RAM port is a single-port, byte-addressed master with a 16-bit data path and combinational read data. Read data is valid in the same cycle as the request and is captured at the next rising edge. The port carries exactly one access per cycle. It is shared by descriptor traffic and data traffic.

Top module: `desc_xfer_engine`

## Requirements
- R1: An activation accepted at a rising edge is followed by six consecutive word reads, one per cycle. They fetch the mode A, mode B, source, destination, count A and count B words, in that order, from the descriptor base plus 0, 2, 4, 6, 8 and 10. No write occurs during these reads.
- R2: Right after the descriptor reads, the engine issues one read at the source address. In the next cycle it issues one write of that data at the destination address.
- R3: Mode A bits 7:6 control the source address after the transfer: 00 or 01 leaves it unchanged, 10 adds the step, and 11 subtracts the step.
- R4: Mode A bits 5:4 control the destination address with the same encoding as R3.
- R5: Mode A bit 0 selects the item size and the step. Value 0 selects a byte: step 1, mem_size low, data on bits 7:0. Value 1 selects a 16-bit word: step 2, mem_size high.
- R6: Every word access, for data or for a descriptor, drives mem_addr bit 0 as 0. Data accesses use the stored address with that bit cleared. The address update is applied to the stored address.
- R7: Count A is decremented by exactly one per activation and wraps from 0000h to FFFFh.
- R8: After the data write, six consecutive word writes store the descriptor back to the same addresses, in the same order as R1. Mode A, mode B and count B come back unchanged.
- R9: done is high for exactly one cycle, 14 rising edges after the accepting edge. done_zero is high together with done exactly when the stored count A is zero.
- R10: An activation request seen while a descriptor cycle is in progress, including a request held high from the accepting cycle, is ignored. Only one descriptor cycle of 14 RAM accesses results.
- R11: While reset is asserted and after its release with no request, mem_req, done and done_zero are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_req | input | 1 | Activation request, sampled while idle |
| act_base | input | AW | Byte address of the descriptor |
| mem_req | output | 1 | RAM access valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = 16-bit word, 0 = byte |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data; bytes use bits 7:0 |
| mem_rdata | input | DW | Combinational read data |
| done | output | 1 | One-cycle completion pulse |
| done_zero | output | 1 | Count A reached zero, valid with done |

## Verification
The hardest situation to create from the ports is a request that arrives while the engine is busy. A second activation and the first one would touch the same RAM, so its effect is easy to hide. The bench holds act_req high through the accepting edge and several busy cycles, and switches act_base to a second, fully populated descriptor during that time. It then checks, from a log of every RAM access, that exactly fourteen accesses hit only the first descriptor. It also checks that the second descriptor and its destination byte are still intact. Odd stored addresses under word mode are a second hard case: the bench uses them to separate the aligned bus address from the unaligned address that is written back.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RDSRC,
      ST_WRDST,
      ST_STORE,
      ST_DONE
   } dxe_state_e;

   // descriptor word slots, in fetch and store order
   localparam int NWORDS  = 6;
   localparam int W_MODEA = 0;
   localparam int W_MODEB = 1;
   localparam int W_SRC   = 2;
   localparam int W_DST   = 3;
   localparam int W_CNTA  = 4;
   localparam int W_CNTB  = 5;

   // mode A field positions
   localparam int SRC_MODE_HI = 7;
   localparam int DST_MODE_HI = 5;
   localparam int SIZE_BIT    = 0;

endpackage

// File: rtl/dxe_addr_step.sv
module dxe_addr_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    mode_i,
   input  logic          wide_i,
   output logic [AW-1:0] next_o
);

   localparam logic [AW-1:0] STEP_NARROW = AW'(1);
   localparam logic [AW-1:0] STEP_WIDE   = AW'(2);

   logic [AW-1:0] step;

   assign step = wide_i ? STEP_WIDE : STEP_NARROW;

   always_comb begin
      unique case (mode_i)
         2'b10:   next_o = addr_i + step;
         2'b11:   next_o = addr_i - step;
         default: next_o = addr_i;
      endcase
   end

endmodule

// File: rtl/dxe_fsm.sv
module dxe_fsm
   import dxe_pkg::*;
#(
   parameter int NW = 6,
   localparam int IW = $clog2(NW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_req,
   output dxe_state_e    st_o,
   output logic [IW-1:0] idx_o,
   output logic          accept_o
);

   localparam logic [IW-1:0] IDX_LAST = IW'(NW - 1);

   dxe_state_e    st;
   logic [IW-1:0] idx;

   assign accept_o = (st == ST_IDLE) && act_req;
   assign st_o     = st;
   assign idx_o    = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         idx <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (act_req) begin
                  st  <= ST_LOAD;
                  idx <= '0;
               end
            end
            ST_LOAD: begin
               if (idx == IDX_LAST) begin
                  st  <= ST_RDSRC;
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_RDSRC: st <= ST_WRDST;
            ST_WRDST: begin
               st  <= ST_STORE;
               idx <= '0;
            end
            ST_STORE: begin
               if (idx == IDX_LAST) begin
                  st  <= ST_DONE;
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2: the destination write always follows the source read
   a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WRDST) |-> ($past(st) == ST_RDSRC));

   // R10: a descriptor fetch only ever starts out of idle
   a_r10_load_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD && idx == '0) |-> ($past(st) == ST_IDLE));

endmodule

// File: rtl/desc_xfer_engine.sv
module desc_xfer_engine
   import dxe_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_req,
   input  logic [AW-1:0] act_base,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_size,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          done,
   output logic          done_zero
);

   localparam int IW    = $clog2(NWORDS);
   localparam int BYTEW = DW / 2;
   localparam int NPTR  = 2;

   if (DW != 16) begin : g_chk_dw
      $error("desc_xfer_engine: DW must be 16");
   end
   if (AW > DW || AW < 2) begin : g_chk_aw
      $error("desc_xfer_engine: AW must lie in 2..DW");
   end

   dxe_state_e    st;
   logic [IW-1:0] idx;
   logic          accept;

   dxe_fsm #(.NW(NWORDS)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_req  (act_req),
      .st_o     (st),
      .idx_o    (idx),
      .accept_o (accept)
   );

   logic [AW-1:0] base_q;
   logic [DW-1:0] wr [NWORDS];
   logic [DW-1:0] data_q;
   logic          wide;
   logic [AW-1:0] ptr_cur  [NPTR];
   logic [AW-1:0] ptr_nxt  [NPTR];
   logic [1:0]    ptr_mode [NPTR];
   logic [AW-1:0] raw_addr;
   logic [AW-1:0] desc_addr;

   assign wide        = wr[W_MODEA][SIZE_BIT];
   assign ptr_cur[0]  = wr[W_SRC][AW-1:0];
   assign ptr_cur[1]  = wr[W_DST][AW-1:0];
   assign ptr_mode[0] = wr[W_MODEA][SRC_MODE_HI -: 2];
   assign ptr_mode[1] = wr[W_MODEA][DST_MODE_HI -: 2];

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      dxe_addr_step #(.AW(AW)) u_step (
         .addr_i (ptr_cur[g]),
         .mode_i (ptr_mode[g]),
         .wide_i (wide),
         .next_o (ptr_nxt[g])
      );
   end

   assign desc_addr = base_q + AW'({idx, 1'b0});

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_size  = 1'b1;
      raw_addr  = desc_addr;
      mem_wdata = '0;
      unique case (st)
         ST_LOAD: mem_req = 1'b1;
         ST_RDSRC: begin
            mem_req  = 1'b1;
            mem_size = wide;
            raw_addr = ptr_cur[0];
         end
         ST_WRDST: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_size  = wide;
            raw_addr  = ptr_cur[1];
            mem_wdata = data_q;
         end
         ST_STORE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = wr[idx];
         end
         default: ;
      endcase
      mem_addr = mem_size ? {raw_addr[AW-1:1], 1'b0} : raw_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         data_q <= '0;
         for (int i = 0; i < NWORDS; i++) wr[i] <= '0;
      end else begin
         if (accept) base_q <= act_base;
         unique case (st)
            ST_LOAD: wr[idx] <= mem_rdata;
            ST_RDSRC: data_q <= wide ? mem_rdata
                                     : {{(DW-BYTEW){1'b0}}, mem_rdata[BYTEW-1:0]};
            ST_WRDST: begin
               wr[W_SRC]  <= DW'(ptr_nxt[0]);
               wr[W_DST]  <= DW'(ptr_nxt[1]);
               wr[W_CNTA] <= wr[W_CNTA] - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign done      = (st == ST_DONE);
   assign done_zero = done && (wr[W_CNTA] == '0);

   // R1: descriptor fetch cycles only read
   a_r1_load_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD) |-> (mem_req && !mem_we));

   // R7: count A drops by one between fetch and store
   a_r7_count_once: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STORE && idx == '0) |-> (wr[W_CNTA] == $past(wr[W_CNTA]) - 1'b1));

   // R8: mode words stay put while the descriptor is written back
   a_r8_modes_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STORE) |-> ($stable(wr[W_MODEA]) && $stable(wr[W_MODEB]) && mem_we));

   // R9: completion is a single-cycle pulse
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/desc_xfer_engine_tb.sv
`timescale 1ns/1ps
module desc_xfer_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        act_req = 1'b0;
   logic [15:0] act_base = '0;
   logic        mem_req, mem_we, mem_size;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        done, done_zero;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   desc_xfer_engine #(.AW(16), .DW(16)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_req   (act_req),
      .act_base  (act_base),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_size  (mem_size),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .done      (done),
      .done_zero (done_zero)
   );

   // byte-addressed RAM model, little-endian words, combinational read
   logic [7:0]  ram [4096];
   logic [11:0] ra;
   logic        pl_we = 1'b0;
   logic        pl_wide = 1'b0;
   logic [11:0] pl_addr = '0;
   logic [15:0] pl_data = '0;

   assign ra = mem_addr[11:0];
   assign mem_rdata = mem_size ? {ram[{ra[11:1], 1'b1}], ram[{ra[11:1], 1'b0}]}
                               : {8'h00, ram[ra]};

   // access log
   logic [15:0] lg_addr [256];
   logic        lg_we   [256];
   logic        lg_sz   [256];
   int          lg_n = 0;

   always @(posedge clk) begin
      if (pl_we) begin
         ram[pl_addr] <= pl_data[7:0];
         if (pl_wide) ram[pl_addr + 12'd1] <= pl_data[15:8];
      end
      if (mem_req && mem_we) begin
         if (mem_size) begin
            ram[{ra[11:1], 1'b0}] <= mem_wdata[7:0];
            ram[{ra[11:1], 1'b1}] <= mem_wdata[15:8];
         end else begin
            ram[ra] <= mem_wdata[7:0];
         end
      end
      if (mem_req && lg_n < 256) begin
         lg_addr[lg_n] <= mem_addr;
         lg_we[lg_n]   <= mem_we;
         lg_sz[lg_n]   <= mem_size;
         lg_n          <= lg_n + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at a negedge
   task automatic put(input logic [11:0] a, input logic [15:0] d, input logic w);
      pl_we = 1'b1; pl_wide = w; pl_addr = a; pl_data = d;
      @(negedge clk);
      pl_we = 1'b0;
   endtask

   function automatic logic [15:0] get16(input logic [11:0] a);
      return {ram[a + 12'd1], ram[a]};
   endfunction

   task automatic set_desc(input logic [11:0] b, input logic [15:0] ma, input logic [15:0] mb,
                           input logic [15:0] s, input logic [15:0] d,
                           input logic [15:0] ca, input logic [15:0] cb);
      put(b,          ma, 1'b1);
      put(b + 12'd2,  mb, 1'b1);
      put(b + 12'd4,  s,  1'b1);
      put(b + 12'd6,  d,  1'b1);
      put(b + 12'd8,  ca, 1'b1);
      put(b + 12'd10, cb, 1'b1);
   endtask

   // one activation; reports latency, done count and done_zero
   task automatic activate(input logic [15:0] b, output int lat, output int ndone, output logic z);
      act_req = 1'b1; act_base = b;
      @(negedge clk);
      act_req = 1'b0;
      lat = 0; ndone = 0; z = 1'b0;
      for (int n = 1; n <= 22; n++) begin
         if (done) begin
            ndone++;
            if (lat == 0) begin lat = n; z = done_zero; end
         end
         @(negedge clk);
      end
   endtask

   task automatic chk_log(input string tag, input int st, input logic [15:0] b,
                          input logic [15:0] sa, input logic [15:0] da, input logic sz);
      logic ok_ld, ok_st, ok_dat;
      ok_ld = 1'b1; ok_st = 1'b1; ok_dat = 1'b1;
      for (int k = 0; k < 6; k++) begin
         if (lg_addr[st+k] !== b + 16'(2*k) || lg_we[st+k] !== 1'b0 || lg_sz[st+k] !== 1'b1)
            ok_ld = 1'b0;
         if (lg_addr[st+8+k] !== b + 16'(2*k) || lg_we[st+8+k] !== 1'b1 || lg_sz[st+8+k] !== 1'b1)
            ok_st = 1'b0;
      end
      if (lg_addr[st+6] !== sa || lg_we[st+6] !== 1'b0) ok_dat = 1'b0;
      if (lg_addr[st+7] !== da || lg_we[st+7] !== 1'b1) ok_dat = 1'b0;
      check({"R1 load sequence ", tag}, 32'(ok_ld), 32'd1);
      check({"R2 data read then write ", tag}, 32'(ok_dat), 32'd1);
      check({"R8 store sequence ", tag}, 32'(ok_st), 32'd1);
      check({"R5 data size ", tag}, {30'd0, lg_sz[st+7], lg_sz[st+6]}, {30'd0, sz, sz});
   endtask

   task automatic t_reset();
      check("R11 mem_req after reset", 32'(mem_req), 32'd0);
      check("R11 done after reset", 32'(done), 32'd0);
      check("R11 done_zero after reset", 32'(done_zero), 32'd0);
   endtask

   // byte, source and destination increment
   task automatic t_byte_inc();
      int st, lat, nd; logic z;
      set_desc(12'h040, 16'h00A0, 16'h1234, 16'h0100, 16'h0200, 16'h0003, 16'h5678);
      put(12'h100, 16'h775A, 1'b1);
      put(12'h200, 16'hEEEE, 1'b1);
      st = lg_n;
      activate(16'h0040, lat, nd, z);
      check("R9 done latency", 32'(lat), 32'd15);
      check("R9 done single pulse", 32'(nd), 32'd1);
      check("R9 done_zero low", 32'(z), 32'd0);
      check("R10 access count", 32'(lg_n - st), 32'd14);
      chk_log("byte_inc", st, 16'h0040, 16'h0100, 16'h0200, 1'b0);
      check("R5 byte written", 32'(get16(12'h200)), 32'h0000EE5A);
      check("R3 src incremented", 32'(get16(12'h044)), 32'h0101);
      check("R4 dst incremented", 32'(get16(12'h046)), 32'h0201);
      check("R7 count decremented", 32'(get16(12'h048)), 32'h0002);
      check("R8 mode A kept", 32'(get16(12'h040)), 32'h00A0);
      check("R8 mode B kept", 32'(get16(12'h042)), 32'h1234);
      check("R8 count B kept", 32'(get16(12'h04A)), 32'h5678);
   endtask

   // word, source decrement, destination fixed, count reaches zero
   task automatic t_word_dec();
      int st, lat, nd; logic z;
      set_desc(12'h060, 16'h00C1, 16'h0000, 16'h0302, 16'h0400, 16'h0001, 16'h0000);
      put(12'h302, 16'hBEEF, 1'b1);
      put(12'h400, 16'h0000, 1'b1);
      st = lg_n;
      activate(16'h0060, lat, nd, z);
      check("R9 done_zero at zero", 32'(z), 32'd1);
      chk_log("word_dec", st, 16'h0060, 16'h0302, 16'h0400, 1'b1);
      check("R5 word written", 32'(get16(12'h400)), 32'h0000BEEF);
      check("R3 src decremented by 2", 32'(get16(12'h064)), 32'h0300);
      check("R4 dst fixed (00)", 32'(get16(12'h066)), 32'h0400);
      check("R7 count to zero", 32'(get16(12'h068)), 32'h0000);
   endtask

   // byte, source fixed (01), destination decrement, count wraps
   task automatic t_dst_dec();
      int st, lat, nd; logic z;
      set_desc(12'h080, 16'h0070, 16'h0000, 16'h0110, 16'h0220, 16'h0000, 16'h0000);
      put(12'h110, 16'h0033, 1'b1);
      put(12'h220, 16'hEE00, 1'b1);
      st = lg_n;
      activate(16'h0080, lat, nd, z);
      check("R9 done_zero after wrap", 32'(z), 32'd0);
      chk_log("dst_dec", st, 16'h0080, 16'h0110, 16'h0220, 1'b0);
      check("R5 byte at dst", 32'(get16(12'h220)), 32'h0000EE33);
      check("R3 src fixed (01)", 32'(get16(12'h084)), 32'h0110);
      check("R4 dst decremented by 1", 32'(get16(12'h086)), 32'h021F);
      check("R7 count wraps", 32'(get16(12'h088)), 32'hFFFF);
   endtask

   // word with odd stored addresses
   task automatic t_word_odd();
      int st, lat, nd; logic z;
      set_desc(12'h0A0, 16'h00A1, 16'h0000, 16'h0501, 16'h0603, 16'h0005, 16'h0000);
      put(12'h500, 16'hCAFE, 1'b1);
      put(12'h602, 16'h0000, 1'b1);
      st = lg_n;
      activate(16'h00A0, lat, nd, z);
      chk_log("word_odd", st, 16'h00A0, 16'h0500, 16'h0602, 1'b1);
      check("R6 word moved to aligned dst", 32'(get16(12'h602)), 32'h0000CAFE);
      check("R6 src step on stored addr", 32'(get16(12'h0A4)), 32'h0503);
      check("R6 dst step on stored addr", 32'(get16(12'h0A6)), 32'h0605);
   endtask

   // request held and base changed while busy
   task automatic t_busy_ignore();
      int st, nd;
      set_desc(12'h0C0, 16'h00A0, 16'h0000, 16'h0130, 16'h0230, 16'h0002, 16'h0000);
      set_desc(12'h0E0, 16'h00A0, 16'h0000, 16'h0140, 16'h0240, 16'h0009, 16'h0000);
      put(12'h130, 16'h0044, 1'b1);
      put(12'h140, 16'h0055, 1'b1);
      put(12'h230, 16'h0000, 1'b1);
      put(12'h240, 16'h00EE, 1'b1);
      st = lg_n; nd = 0;
      act_req = 1'b1; act_base = 16'h00C0;
      @(negedge clk);
      act_base = 16'h00E0;
      for (int n = 1; n <= 30; n++) begin
         if (n == 8) act_req = 1'b0;
         if (done) nd++;
         @(negedge clk);
      end
      check("R10 single done", 32'(nd), 32'd1);
      check("R10 access count", 32'(lg_n - st), 32'd14);
      chk_log("busy", st, 16'h00C0, 16'h0130, 16'h0230, 1'b0);
      check("R10 first transfer done", 32'(get16(12'h230)), 32'h00000044);
      check("R10 second dst untouched", 32'(get16(12'h240)), 32'h000000EE);
      check("R10 second count untouched", 32'(get16(12'h0E8)), 32'h0009);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_byte_inc();
      t_word_dec();
      t_dst_dec();
      t_word_odd();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R9: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule